// File: doc/BRIEF.md
# Operand Addressing Bus Sequencer

This block walks an 8-bit processor through the bus cycles that locate and fetch the operand of a memory-reading or read-modify-write instruction. It is started with a program address. From there it fetches the opcode and any operand bytes, and it builds the effective address in one of seven modes: page-zero direct, page-zero plus X, full 16-bit direct, 16-bit plus X, 16-bit plus Y, pointer in page zero chosen by operand plus X, and pointer in page zero with Y added to its value. It then reads the data.

The bus carries exactly one access per clock. It is a plain synchronous port: an address, an enable, a write select and write data out, and read data that is valid in the same cycle. The fetched operand is presented on a side output together with a strobe. For the left-shift read-modify-write group, the block writes the original byte back first and then writes the shifted byte. A done pulse marks the last cycle of each instruction. A small decode table inside the block maps the opcode to a mode.

Top module: `amode_seq`

## Requirements
- R1: While rst_n is low and afterwards until go is seen, bus_en, done and opnd_valid are 0.
- R2: Page-zero direct (opcode low bits 01, bits 4:2 = 001) takes 3 cycles. The cycles are opcode at pc_start, operand byte at pc_start+1, then a read at {0x00, operand}. That read cycle carries opnd_valid=1, opnd_data=bus_rdata and done=1.
- R3: 16-bit direct (bits 4:2 = 011) takes 4 cycles. It reads the low address byte and then the high address byte from consecutive program addresses, then reads the data. pc_next ends at pc_start+3.
- R4: In 16-bit indexed mode (bits 4:2 = 111 adds X, 110 adds Y), the index is added to the low byte. When that add does not carry, the instruction ends after one read at {high, low+index} in 4 cycles.
- R5: When the low-byte add in 16-bit indexed mode carries, a first read goes to {high, (low+index) mod 256} and a second read goes to {high+1, same low}. Only the second read is valid, and the instruction takes 5 cycles.
- R6: Page-zero plus X (bits 4:2 = 101) does a discard read at {0x00, operand}, then reads {0x00, (operand+X) mod 256}, taking 4 cycles.
- R7: Pointer-plus-X mode (bits 4:2 = 000) reads the discard base, then the pointer low byte at (operand+X) mod 256 and the high byte at (operand+X+1) mod 256, both in page zero. It then reads the data at the pointer, taking 6 cycles.
- R8: Pointer-then-Y mode (bits 4:2 = 100) reads the pointer at operand and (operand+1) mod 256 in page zero and adds Y to its low byte. It then follows R4/R5, taking 5 cycles without a carry or 6 with one.
- R9: The shift group (opcode bits 7:5 = 000, low bits 10, bits 4:2 in 001, 011, 101, 111 for page-zero, 16-bit, page-zero+X, 16-bit+X) reads the byte, writes it back unchanged, then writes it shifted left with bit 0 cleared. In that final write cycle, shl_carry equals the original bit 7.
- R10: The 16-bit+X shift form always performs the second read, even without a carry, and takes 7 cycles.
- R11: Any other opcode, including low bits 01 with bits 4:2 = 010, is unsupported. It ends with done in the opcode cycle itself, and pc_next = pc_start+1.
- R12: done is a one-cycle pulse followed by an idle cycle with bus_en=0. A go arriving while an instruction is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start an instruction (accepted only when idle) |
| pc_start | input | ADDR_W | Address of the opcode to fetch |
| idx_x | input | DATA_W | X index value, held steady during an instruction |
| idx_y | input | DATA_W | Y index value, held steady during an instruction |
| pc_next | output | ADDR_W | Program address following the bytes consumed |
| bus_en | output | 1 | A bus access happens this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid in the access cycle |
| opnd_data | output | DATA_W | Fetched operand |
| opnd_valid | output | 1 | opnd_data is the final operand this cycle |
| shl_carry | output | 1 | Bit shifted out, meaningful with done on a shift instruction |
| done | output | 1 | Last cycle of the instruction |

## Verification
The assertions take reset to be held low across at least one clock edge. They also take the index inputs to be steady from go until done. Given those, the write pair, the shift relation and the idle cycle after done follow from the block's own outputs whatever the read data. The bench changes idx_x, idx_y and pc_start only while the block is idle. Its one exception is a deliberate go pulse carrying a different pc_start during a running instruction, which must leave the bus trace unchanged.

// File: rtl/amode_pkg.sv
package amode_pkg;

   typedef enum logic [2:0] {
      MD_NONE, MD_ZP, MD_ZPX, MD_ABS, MD_ABSX, MD_ABSY, MD_INDX, MD_INDY
   } mode_e;

   typedef enum logic [3:0] {
      S_IDLE, S_OPC, S_OPLO, S_OPHI, S_ZPDUM, S_PTRLO, S_PTRHI,
      S_READ1, S_FIX, S_WOLD, S_WNEW
   } state_e;

endpackage

// File: rtl/amode_decode.sv
module amode_decode
   import amode_pkg::*;
(
   input  logic [7:0] opc,
   output mode_e      mode,
   output logic       rmw
);
   always_comb begin
      mode = MD_NONE;
      rmw  = 1'b0;
      if (opc[1:0] == 2'b01) begin
         unique case (opc[4:2])
            3'b000: mode = MD_INDX;
            3'b001: mode = MD_ZP;
            3'b011: mode = MD_ABS;
            3'b100: mode = MD_INDY;
            3'b101: mode = MD_ZPX;
            3'b110: mode = MD_ABSY;
            3'b111: mode = MD_ABSX;
            default: mode = MD_NONE;
         endcase
      end else if (opc[1:0] == 2'b10 && opc[7:5] == 3'b000) begin
         rmw = 1'b1;
         unique case (opc[4:2])
            3'b001: mode = MD_ZP;
            3'b011: mode = MD_ABS;
            3'b101: mode = MD_ZPX;
            3'b111: mode = MD_ABSX;
            default: begin
               mode = MD_NONE;
               rmw  = 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/amode_add.sv
module amode_add #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] s,
   output logic         co
);
   assign {co, s} = {1'b0, a} + {1'b0, b};
endmodule

// File: rtl/amode_shift.sv
module amode_shift #(
   parameter int W = 8
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         cout
);
   assign dout = {din[W-2:0], 1'b0};
   assign cout = din[W-1];
endmodule

// File: rtl/amode_seq.sv
module amode_seq
   import amode_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 16,
   parameter bit RMW_FIX_ALWAYS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] pc_start,
   input  logic [DATA_W-1:0] idx_x,
   input  logic [DATA_W-1:0] idx_y,
   output logic [ADDR_W-1:0] pc_next,
   output logic              bus_en,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] opnd_data,
   output logic              opnd_valid,
   output logic              shl_carry,
   output logic              done
);
   localparam int PAGE_W = ADDR_W - DATA_W;
   localparam logic [PAGE_W-1:0] PAGE0 = '0;
   localparam logic [DATA_W-1:0] ONE   = DATA_W'(1);

   if (ADDR_W != 2 * DATA_W || DATA_W < 8) begin : g_bad_param
      initial $fatal(1, "amode_seq: ADDR_W must be twice DATA_W, DATA_W >= 8");
   end

   state_e            st_q, st_d;
   mode_e             mode_q, mode_d, dec_mode;
   logic              rmw_q, rmw_d, dec_rmw;
   logic [ADDR_W-1:0] pc_q, pc_d;
   logic [DATA_W-1:0] adl_q, adl_d, adh_q, adh_d, tmp_q, tmp_d, old_q, old_d;
   logic              cy_q, cy_d;

   // index adder: low-byte + index, carry tracked
   logic [DATA_W-1:0] ix_a, ix_b, ix_s;
   logic              ix_co;
   // incrementer: pointer+1 in page zero, high byte fix-up
   logic [DATA_W-1:0] inc_a, inc_b, inc_s;
   logic              inc_co;
   logic [DATA_W-1:0] shl_val;
   logic              shl_co;
   logic              rmw_force, indexed, need_fix;

   amode_decode u_dec (.opc(bus_rdata[7:0]), .mode(dec_mode), .rmw(dec_rmw));

   amode_add #(.W(DATA_W)) u_ix  (.a(ix_a),  .b(ix_b),  .s(ix_s),  .co(ix_co));
   amode_add #(.W(DATA_W)) u_inc (.a(inc_a), .b(inc_b), .s(inc_s), .co(inc_co));

   amode_shift #(.W(DATA_W)) u_shl (.din(old_q), .dout(shl_val), .cout(shl_co));

   if (RMW_FIX_ALWAYS) begin : g_fix_always
      assign rmw_force = rmw_q;
   end else begin : g_fix_carry
      assign rmw_force = 1'b0;
   end

   assign indexed  = (mode_q == MD_ABSX) || (mode_q == MD_ABSY) || (mode_q == MD_INDY);
   assign need_fix = indexed && (cy_q || rmw_force);

   always_comb begin
      ix_a = adl_q;
      ix_b = (mode_q == MD_ABSY || mode_q == MD_INDY) ? idx_y : idx_x;
      if (st_q == S_PTRHI) ix_a = tmp_q;
      inc_a = (st_q == S_FIX) ? adh_q : adl_q;
      inc_b = (st_q == S_FIX) ? {{(DATA_W-1){1'b0}}, cy_q} : ONE;
   end

   always_comb begin
      st_d   = st_q;
      mode_d = mode_q;
      rmw_d  = rmw_q;
      pc_d   = pc_q;
      adl_d  = adl_q;
      adh_d  = adh_q;
      tmp_d  = tmp_q;
      old_d  = old_q;
      cy_d   = cy_q;
      bus_en     = 1'b1;
      bus_we     = 1'b0;
      bus_addr   = {adh_q, adl_q};
      bus_wdata  = old_q;
      opnd_valid = 1'b0;
      done       = 1'b0;
      unique case (st_q)
         S_IDLE: begin
            bus_en = 1'b0;
            if (go) begin
               pc_d = pc_start;
               st_d = S_OPC;
            end
         end
         S_OPC: begin
            bus_addr = pc_q;
            pc_d     = pc_q + 1'b1;
            mode_d   = dec_mode;
            rmw_d    = dec_rmw;
            if (dec_mode == MD_NONE) begin
               done = 1'b1;
               st_d = S_IDLE;
            end else begin
               st_d = S_OPLO;
            end
         end
         S_OPLO: begin
            bus_addr = pc_q;
            pc_d     = pc_q + 1'b1;
            adl_d    = bus_rdata;
            adh_d    = '0;
            cy_d     = 1'b0;
            unique case (mode_q)
               MD_ZP:              st_d = S_READ1;
               MD_ZPX, MD_INDX:    st_d = S_ZPDUM;
               MD_INDY:            st_d = S_PTRLO;
               default:            st_d = S_OPHI;
            endcase
         end
         S_OPHI: begin
            bus_addr = pc_q;
            pc_d     = pc_q + 1'b1;
            adh_d    = bus_rdata;
            if (mode_q == MD_ABSX || mode_q == MD_ABSY) begin
               adl_d = ix_s;
               cy_d  = ix_co;
            end
            st_d = S_READ1;
         end
         S_ZPDUM: begin
            bus_addr = {PAGE0, adl_q};
            adl_d    = ix_s;
            st_d     = (mode_q == MD_INDX) ? S_PTRLO : S_READ1;
         end
         S_PTRLO: begin
            bus_addr = {PAGE0, adl_q};
            tmp_d    = bus_rdata;
            st_d     = S_PTRHI;
         end
         S_PTRHI: begin
            bus_addr = {PAGE0, inc_s};
            adh_d    = bus_rdata;
            if (mode_q == MD_INDY) begin
               adl_d = ix_s;
               cy_d  = ix_co;
            end else begin
               adl_d = tmp_q;
               cy_d  = 1'b0;
            end
            st_d = S_READ1;
         end
         S_READ1, S_FIX: begin
            if (st_q == S_FIX) begin
               bus_addr = {inc_s, adl_q};
               adh_d    = inc_s;
            end
            if (st_q == S_READ1 && need_fix) begin
               st_d = S_FIX;
            end else if (rmw_q) begin
               old_d = bus_rdata;
               st_d  = S_WOLD;
            end else begin
               opnd_valid = 1'b1;
               done       = 1'b1;
               st_d       = S_IDLE;
            end
         end
         S_WOLD: begin
            bus_we = 1'b1;
            st_d   = S_WNEW;
         end
         S_WNEW: begin
            bus_we    = 1'b1;
            bus_wdata = shl_val;
            done      = 1'b1;
            st_d      = S_IDLE;
         end
         default: st_d = S_IDLE;
      endcase
   end

   assign opnd_data = bus_rdata;
   assign shl_carry = shl_co;
   assign pc_next   = pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         mode_q <= MD_NONE;
         rmw_q  <= 1'b0;
         pc_q   <= '0;
         adl_q  <= '0;
         adh_q  <= '0;
         tmp_q  <= '0;
         old_q  <= '0;
         cy_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         mode_q <= mode_d;
         rmw_q  <= rmw_d;
         pc_q   <= pc_d;
         adl_q  <= adl_d;
         adh_q  <= adh_d;
         tmp_q  <= tmp_d;
         old_q  <= old_d;
         cy_q   <= cy_d;
      end
   end

   logic unused_inc_co;
   assign unused_inc_co = inc_co;
endmodule

// File: rtl/amode_seq_chk.sv
module amode_seq_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              go,
   input logic [ADDR_W-1:0] pc_next,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              opnd_valid,
   input logic              shl_carry,
   input logic              done
);
   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r12_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !bus_en);

   a_r12_done_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> bus_en);

   a_r2_valid_is_final_read: assert property (@(posedge clk) disable iff (!rst_n)
      opnd_valid |-> (done && bus_en && !bus_we));

   a_r9_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && !done) |=> (bus_en && bus_we && done && bus_addr == $past(bus_addr)));

   a_r9_shift_value: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && !done) |=>
         (bus_wdata == {$past(bus_wdata[DATA_W-2:0]), 1'b0} && shl_carry == $past(bus_wdata[DATA_W-1])));

   a_r3_pc_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_en && !go) |=> $stable(pc_next));
endmodule

bind amode_seq amode_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .go(go), .pc_next(pc_next), .bus_en(bus_en),
   .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .opnd_valid(opnd_valid), .shl_carry(shl_carry), .done(done)
);

// File: tb/tb_amode_seq.sv
`timescale 1ns/1ps
module tb_amode_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0;
   logic [15:0] pc_start = '0;
   logic [7:0]  idx_x = '0, idx_y = '0;
   logic [15:0] pc_next, bus_addr;
   logic        bus_en, bus_we, opnd_valid, shl_carry, done;
   logic [7:0]  bus_wdata, bus_rdata, opnd_data;

   logic [7:0]  mem [0:4095];
   int checks = 0, errors = 0;

   logic [15:0] tr_addr [0:11];
   logic        tr_we   [0:11];
   logic [7:0]  tr_wd   [0:11];
   int          ncyc;
   logic [7:0]  got_data;
   logic        got_valid, got_c;
   logic [15:0] got_pc;

   always #10 clk = ~clk;

   assign bus_rdata = mem[bus_addr[11:0]];

   amode_seq dut (
      .clk(clk), .rst_n(rst_n), .go(go), .pc_start(pc_start),
      .idx_x(idx_x), .idx_y(idx_y), .pc_next(pc_next),
      .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .opnd_data(opnd_data), .opnd_valid(opnd_valid),
      .shl_carry(shl_carry), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   // runs one instruction; poke asserts go with another pc in cycle 2
   task automatic run(input logic [15:0] p, input logic [7:0] x, input logic [7:0] y,
                      input bit poke);
      @(negedge clk);
      idx_x = x; idx_y = y; pc_start = p; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      ncyc = 0; got_valid = 1'b0; got_data = '0; got_c = 1'b0;
      forever begin
         tr_addr[ncyc] = bus_addr;
         tr_we[ncyc]   = bus_we && bus_en;
         tr_wd[ncyc]   = bus_wdata;
         if (opnd_valid) begin
            got_valid = 1'b1;
            got_data  = opnd_data;
         end
         if (bus_en && bus_we) mem[bus_addr[11:0]] = bus_wdata;
         ncyc++;
         if (done) begin
            got_c = shl_carry;
            break;
         end
         if (ncyc >= 12) break;
         if (poke && ncyc == 1) begin
            pc_start = 16'h0800; go = 1'b1;
         end else begin
            go = 1'b0;
         end
         @(negedge clk);
      end
      go = 1'b0;
      @(negedge clk);
      got_pc = pc_next;
      chk_eq("R12 idle after done", int'(bus_en), 0);
   endtask

   task automatic t_reset();
      chk_eq("R1 bus_en in reset", int'(bus_en), 0);
      chk_eq("R1 done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk_eq("R1 bus_en idle", int'(bus_en), 0);
      chk_eq("R1 valid idle", int'(opnd_valid), 0);
   endtask

   task automatic t_zp(input bit poke);
      mem[12'h200] = 8'h05; mem[12'h201] = 8'h40; mem[12'h040] = 8'h5A;
      run(16'h0200, 8'h00, 8'h00, poke);
      chk_eq("R2 zp cycles", ncyc, 3);
      chk_eq("R2 zp opcode addr", int'(tr_addr[0]), 16'h0200);
      chk_eq("R2 zp read addr", int'(tr_addr[2]), 16'h0040);
      chk_eq("R2 zp data", int'(got_data), 8'h5A);
      chk_eq("R2 zp valid", int'(got_valid), 1);
      if (poke) chk_eq("R12 go ignored pc", int'(got_pc), 16'h0202);
   endtask

   task automatic t_abs();
      mem[12'h210] = 8'h0D; mem[12'h211] = 8'h34; mem[12'h212] = 8'h03;
      mem[12'h334] = 8'hC3;
      run(16'h0210, 8'h00, 8'h00, 1'b0);
      chk_eq("R3 abs cycles", ncyc, 4);
      chk_eq("R3 abs hi fetch addr", int'(tr_addr[2]), 16'h0212);
      chk_eq("R3 abs read addr", int'(tr_addr[3]), 16'h0334);
      chk_eq("R3 abs data", int'(got_data), 8'hC3);
      chk_eq("R3 abs pc_next", int'(got_pc), 16'h0213);
   endtask

   task automatic t_absx_nocarry();
      mem[12'h220] = 8'h1D; mem[12'h221] = 8'h10; mem[12'h222] = 8'h03;
      mem[12'h315] = 8'h77;
      run(16'h0220, 8'h05, 8'h00, 1'b0);
      chk_eq("R4 absx cycles", ncyc, 4);
      chk_eq("R4 absx addr", int'(tr_addr[3]), 16'h0315);
      chk_eq("R4 absx data", int'(got_data), 8'h77);
   endtask

   task automatic t_absy_carry();
      mem[12'h230] = 8'h19; mem[12'h231] = 8'hF0; mem[12'h232] = 8'h03;
      mem[12'h310] = 8'h11; mem[12'h410] = 8'h99;
      run(16'h0230, 8'h00, 8'h20, 1'b0);
      chk_eq("R5 absy cycles", ncyc, 5);
      chk_eq("R5 absy first read", int'(tr_addr[3]), 16'h0310);
      chk_eq("R5 absy fixed read", int'(tr_addr[4]), 16'h0410);
      chk_eq("R5 absy data", int'(got_data), 8'h99);
   endtask

   task automatic t_zpx();
      mem[12'h240] = 8'h15; mem[12'h241] = 8'hF0; mem[12'h010] = 8'h3C;
      run(16'h0240, 8'h20, 8'h00, 1'b0);
      chk_eq("R6 zpx cycles", ncyc, 4);
      chk_eq("R6 zpx discard addr", int'(tr_addr[2]), 16'h00F0);
      chk_eq("R6 zpx wrapped addr", int'(tr_addr[3]), 16'h0010);
      chk_eq("R6 zpx data", int'(got_data), 8'h3C);
   endtask

   task automatic t_indx();
      mem[12'h250] = 8'h01; mem[12'h251] = 8'h80;
      mem[12'h0FF] = 8'h12; mem[12'h000] = 8'h05; mem[12'h512] = 8'hE1;
      run(16'h0250, 8'h7F, 8'h00, 1'b0);
      chk_eq("R7 indx cycles", ncyc, 6);
      chk_eq("R7 indx ptr lo addr", int'(tr_addr[3]), 16'h00FF);
      chk_eq("R7 indx ptr hi wrap", int'(tr_addr[4]), 16'h0000);
      chk_eq("R7 indx data addr", int'(tr_addr[5]), 16'h0512);
      chk_eq("R7 indx data", int'(got_data), 8'hE1);
   endtask

   task automatic t_indy(input logic [7:0] y, input int exp_cyc, input logic [15:0] exp_addr,
                         input logic [7:0] exp_dat);
      mem[12'h260] = 8'h11; mem[12'h261] = 8'h20;
      mem[12'h020] = 8'hC0; mem[12'h021] = 8'h06;
      mem[12'h6D0] = 8'h4D; mem[12'h610] = 8'h21; mem[12'h710] = 8'hB7;
      run(16'h0260, 8'h00, y, 1'b0);
      chk_eq("R8 indy cycles", ncyc, exp_cyc);
      chk_eq("R8 indy ptr hi addr", int'(tr_addr[3]), 16'h0021);
      chk_eq("R8 indy data addr", int'(tr_addr[ncyc-1]), int'(exp_addr));
      chk_eq("R8 indy data", int'(got_data), int'(exp_dat));
   endtask

   task automatic t_rmw_zp();
      mem[12'h270] = 8'h06; mem[12'h271] = 8'h30; mem[12'h030] = 8'h81;
      run(16'h0270, 8'h00, 8'h00, 1'b0);
      chk_eq("R9 rmw cycles", ncyc, 5);
      chk_eq("R9 rmw old write", int'(tr_we[3]), 1);
      chk_eq("R9 rmw old data", int'(tr_wd[3]), 8'h81);
      chk_eq("R9 rmw new data", int'(tr_wd[4]), 8'h02);
      chk_eq("R9 rmw addr", int'(tr_addr[4]), 16'h0030);
      chk_eq("R9 rmw carry", int'(got_c), 1);
      chk_eq("R9 rmw mem", int'(mem[12'h030]), 8'h02);
      chk_eq("R9 rmw no operand strobe", int'(got_valid), 0);
   endtask

   task automatic t_rmw_absx();
      mem[12'h280] = 8'h1E; mem[12'h281] = 8'h00; mem[12'h282] = 8'h03;
      mem[12'h301] = 8'h40;
      run(16'h0280, 8'h01, 8'h00, 1'b0);
      chk_eq("R10 rmw absx cycles", ncyc, 7);
      chk_eq("R10 first read", int'(tr_addr[3]), 16'h0301);
      chk_eq("R10 second read", int'(tr_addr[4]), 16'h0301);
      chk_eq("R10 second read is read", int'(tr_we[4]), 0);
      chk_eq("R10 new data", int'(tr_wd[6]), 8'h80);
      chk_eq("R10 carry", int'(got_c), 0);
   endtask

   task automatic t_unsup(input logic [7:0] opc);
      mem[12'h290] = opc;
      run(16'h0290, 8'h00, 8'h00, 1'b0);
      chk_eq("R11 unsupported cycles", ncyc, 1);
      chk_eq("R11 unsupported pc", int'(got_pc), 16'h0291);
      chk_eq("R11 unsupported no strobe", int'(got_valid), 0);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      t_zp(1'b0);
      t_zp(1'b1);           // R12 go during a running instruction
      t_abs();
      t_absx_nocarry();
      t_absy_carry();
      t_zpx();
      t_indx();
      t_indy(8'h10, 5, 16'h06D0, 8'h4D);
      t_indy(8'h50, 6, 16'h0710, 8'hB7);
      t_rmw_zp();
      t_rmw_absx();
      t_unsup(8'h09);
      t_unsup(8'h26);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule